// File: doc/BRIEF.md
# Hardwired Micro-Operation Control Sequencer

This block is a small accumulator processor whose control is hardwired. Every instruction runs as a fixed, timed list of register transfers between five registers: memory address (MAR), memory buffer (MBR), program counter (PC), instruction (IR) and accumulator (ACC). A step counter marks the phases t1 to t4 of each major cycle. A register holds the major cycle: fetch, indirect, execute or interrupt. An opcode decoder gives one active line per instruction. Each register load and memory strobe is a logic function of the phase, the major cycle, the decoded line, the MBR contents and the interrupt state. The phases are grouped so that no register is read and written in the same step.

The core drives a single-port word memory. The address always comes from MAR and the write data always comes from MBR. In a cycle with the read strobe high, the memory presents the addressed word on the read-data input, and MBR captures it at the edge that closes that cycle. A write strobe stores MBR at the addressed location on the same edge. An interrupt request input diverts the core to a fixed service address after the current execute cycle completes. The halt output rises when a halt instruction runs.

Top module: `hwseq_core`

## Requirements
- R1: While reset is low and in the first cycle after it, PC and ACC read 0, halted is low, and neither memory strobe is active. Interrupts are enabled by reset, and the first major cycle is a fetch from address 0.
- R2: Fetch takes three steps. In t1 MAR takes PC. In t2 the read strobe is high with mem_addr equal to the old PC, MBR captures the word, and PC advances by one. In t3 IR takes MBR. A memory capture into MBR never shares a step with an IR load. A read never occurs unless MAR was loaded in the step before.
- R3: An instruction word has the indirect flag in bit 15, the opcode in bits 14:12 and the address X in bits 11:0. The opcodes are ADD=0, ISZ=1, BSA=2 and HLT=7.
- R4: ADD sets ACC to (ACC + M[X]) mod 2^16 in a three-step execute cycle, so a direct ADD takes 6 clocks including its fetch.
- R5: ISZ writes M[X]+1 (mod 2^16) back to X in a four-step execute cycle. When the written value is 0, PC advances by one more, so the next instruction is skipped.
- R6: BSA writes the address of the following instruction, zero-extended, to M[X], and execution resumes at X+1. It takes three execute steps.
- R7: When bit 15 is set, a three-step indirect cycle runs between fetch and execute. The effective address becomes bits 11:0 of M[X], and the instruction then behaves exactly as its direct form does on that address.
- R8: HLT raises halted in the first execute step. Halted then stays high until reset, no further memory strobe occurs, PC stays at the word after the HLT, and a program ending in HLT after two direct ADDs halts on the 16th clock.
- R9: If irq_req is high while interrupts are enabled at the end of an execute cycle, a three-step interrupt cycle runs. It writes the current PC to address 0, sets PC to 1 and disables interrupts until the next reset, so a request held high causes exactly one interrupt.
- R10: Opcodes 3 to 6 do nothing. Their execute cycle lasts a single step and leaves ACC, PC and memory unchanged.
- R11: The step counter returns to t1 whenever the major cycle changes, and the read and write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Level interrupt request |
| mem_addr | output | 12 | Memory word address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_rdata | input | 16 | Memory read data, valid in the cycle mem_rd is high |
| mem_rd | output | 1 | Read strobe; MBR captures mem_rdata at the closing edge |
| mem_wr | output | 1 | Write strobe; memory stores mem_wdata at the closing edge |
| halted | output | 1 | High after a halt instruction has run |
| acc_out | output | 16 | Accumulator contents |
| pc_out | output | 12 | Program counter contents |

## Verification
The assertions assume that the memory answers a read within the strobe cycle and needs no wait states. They also assume that irq_req is a clean synchronous level, and that reset is applied before the first instruction. The bench models the memory as an array read combinationally at mem_addr and written on the clock edge. It changes irq_req and the memory contents only while reset is held, and it keeps every program and operand inside a 256-word window, so those assumptions always hold. The bench predicts every memory write in program order and compares it as it happens. It also compares final ACC, PC, memory words and the halt time against counts derived from the step lengths in the requirements.

// File: rtl/hwseq_pkg.sv
package hwseq_pkg;

  localparam int WORD_W  = 16;
  localparam int ADDR_W  = 12;
  localparam int OPC_W   = 3;
  localparam int OPC_LSB = ADDR_W;
  localparam int IND_BIT = WORD_W - 1;
  localparam int OPC_N   = 1 << OPC_W;

  localparam int OP_ADD = 0;
  localparam int OP_ISZ = 1;
  localparam int OP_BSA = 2;
  localparam int OP_HLT = 7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OPC_W-1:0]  opc_t;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_IND   = 2'd1,
    CYC_EXEC  = 2'd2,
    CYC_INT   = 2'd3
  } cyc_e;

  typedef enum logic [1:0] {
    T1 = 2'd0,
    T2 = 2'd1,
    T3 = 2'd2,
    T4 = 2'd3
  } step_e;

  // one bit per register transfer or strobe of a step
  typedef struct packed {
    logic mar_pc;
    logic mar_ir;
    logic mar_save;
    logic mbr_mem;
    logic mbr_pc;
    logic mbr_inc;
    logic ir_all;
    logic ir_addr;
    logic pc_inc;
    logic pc_ir;
    logic pc_isr;
    logic acc_add;
    logic mem_rd;
    logic mem_wr;
    logic halt_set;
    logic ien_clr;
    logic last;
    cyc_e next;
  } ctrl_t;

  function automatic word_t word_add(word_t a, word_t b);
    return a + b;
  endfunction

  function automatic word_t word_inc(word_t a);
    return a + word_t'(1);
  endfunction

  function automatic addr_t addr_inc(addr_t a);
    return a + addr_t'(1);
  endfunction

  function automatic addr_t addr_of(word_t w);
    return w[ADDR_W-1:0];
  endfunction

  function automatic opc_t opc_of(word_t w);
    return w[OPC_LSB +: OPC_W];
  endfunction

  function automatic word_t widen_addr(addr_t a);
    return word_t'(a);
  endfunction

endpackage

// File: rtl/hwseq_timer.sv
module hwseq_timer
  import hwseq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  last,
  output step_e step
);

  logic [1:0] step_nxt;

  assign step_nxt = step + 2'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= T1;
    end else if (adv) begin
      step <= last ? T1 : step_e'(step_nxt);
    end
  end

endmodule

// File: rtl/hwseq_decode.sv
module hwseq_decode #(
  parameter int W = hwseq_pkg::OPC_W,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] opc,
  output logic [N-1:0] oh
);

  for (genvar g = 0; g < N; g++) begin : g_line
    assign oh[g] = (opc == W'(g));
  end

endmodule

// File: rtl/hwseq_ctrl.sv
module hwseq_ctrl
  import hwseq_pkg::*;
(
  input  cyc_e             cyc,
  input  step_e            step,
  input  logic [OPC_N-1:0] op_oh,
  input  word_t            mbr,
  input  logic             irq_pend,
  input  logic             halted,
  output ctrl_t            c
);

  logic is_add, is_isz, is_bsa, is_hlt, is_other, mbr_zero, mbr_ind;

  assign is_add   = op_oh[OP_ADD];
  assign is_isz   = op_oh[OP_ISZ];
  assign is_bsa   = op_oh[OP_BSA];
  assign is_hlt   = op_oh[OP_HLT];
  assign is_other = (|op_oh) & ~(is_add | is_isz | is_bsa | is_hlt);
  assign mbr_zero = (mbr == '0);
  assign mbr_ind  = mbr[IND_BIT];

  always_comb begin
    c      = '0;
    c.next = cyc;
    if (!halted) begin
      case (cyc)
        CYC_FETCH: begin
          case (step)
            T1: c.mar_pc = 1'b1;
            T2: begin
              c.mem_rd  = 1'b1;
              c.mbr_mem = 1'b1;
              c.pc_inc  = 1'b1;
            end
            T3: begin
              c.ir_all = 1'b1;
              c.last   = 1'b1;
              c.next   = mbr_ind ? CYC_IND : CYC_EXEC;
            end
            default: ;
          endcase
        end
        CYC_IND: begin
          case (step)
            T1: c.mar_ir = 1'b1;
            T2: begin
              c.mem_rd  = 1'b1;
              c.mbr_mem = 1'b1;
            end
            T3: begin
              c.ir_addr = 1'b1;
              c.last    = 1'b1;
              c.next    = CYC_EXEC;
            end
            default: ;
          endcase
        end
        CYC_EXEC: begin
          if (is_add || is_isz) begin
            case (step)
              T1: c.mar_ir = 1'b1;
              T2: begin
                c.mem_rd  = 1'b1;
                c.mbr_mem = 1'b1;
              end
              default: ;
            endcase
          end
          if (is_add && step == T3) begin
            c.acc_add = 1'b1;
            c.last    = 1'b1;
          end
          if (is_isz && step == T3) c.mbr_inc = 1'b1;
          if (is_isz && step == T4) begin
            c.mem_wr = 1'b1;
            c.pc_inc = mbr_zero;
            c.last   = 1'b1;
          end
          if (is_bsa) begin
            case (step)
              T1: begin
                c.mar_ir = 1'b1;
                c.mbr_pc = 1'b1;
              end
              T2: begin
                c.pc_ir  = 1'b1;
                c.mem_wr = 1'b1;
              end
              T3: begin
                c.pc_inc = 1'b1;
                c.last   = 1'b1;
              end
              default: ;
            endcase
          end
          if (is_hlt && step == T1) c.halt_set = 1'b1;
          if (is_other && step == T1) c.last = 1'b1;
          if (c.last) c.next = irq_pend ? CYC_INT : CYC_FETCH;
        end
        CYC_INT: begin
          case (step)
            T1: begin
              c.mbr_pc  = 1'b1;
              c.ien_clr = 1'b1;
            end
            T2: begin
              c.mar_save = 1'b1;
              c.pc_isr   = 1'b1;
            end
            T3: begin
              c.mem_wr = 1'b1;
              c.last   = 1'b1;
              c.next   = CYC_FETCH;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/hwseq_regs.sv
module hwseq_regs
  import hwseq_pkg::*;
#(
  parameter addr_t SAVE_ADDR = 12'h000,
  parameter addr_t ISR_ADDR  = 12'h001
) (
  input  logic  clk,
  input  logic  rst_n,
  input  ctrl_t c,
  input  word_t mem_rdata,
  output addr_t mar,
  output word_t mbr,
  output addr_t pc,
  output opc_t  op_field,
  output word_t acc
);

  word_t ir;

  assign op_field = opc_of(ir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mar <= '0;
      mbr <= '0;
      pc  <= '0;
      ir  <= '0;
      acc <= '0;
    end else begin
      if (c.mar_pc)        mar <= pc;
      else if (c.mar_ir)   mar <= addr_of(ir);
      else if (c.mar_save) mar <= SAVE_ADDR;

      if (c.mbr_mem)      mbr <= mem_rdata;
      else if (c.mbr_pc)  mbr <= widen_addr(pc);
      else if (c.mbr_inc) mbr <= word_inc(mbr);

      if (c.pc_isr)      pc <= ISR_ADDR;
      else if (c.pc_ir)  pc <= addr_of(ir);
      else if (c.pc_inc) pc <= addr_inc(pc);

      if (c.ir_all)       ir <= mbr;
      else if (c.ir_addr) ir[ADDR_W-1:0] <= addr_of(mbr);

      if (c.acc_add) acc <= word_add(acc, mbr);
    end
  end

endmodule

// File: rtl/hwseq_core.sv
module hwseq_core
  import hwseq_pkg::*;
#(
  parameter addr_t SAVE_ADDR = 12'h000,
  parameter addr_t ISR_ADDR  = 12'h001
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              halted,
  output logic [WORD_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out
);

  cyc_e             cyc_q;
  step_e            step;
  ctrl_t            c;
  logic             ien_q;
  logic             halted_q;
  opc_t             op_field;
  logic [OPC_N-1:0] op_oh;
  word_t            mbr;
  addr_t            mar;
  addr_t            pc;
  word_t            acc;

  // named internal events for the checker
  logic       ev_mar_load, ev_mem_capture, ev_ir_load;
  logic [1:0] cyc_bits, step_bits;

  assign ev_mar_load    = c.mar_pc | c.mar_ir | c.mar_save;
  assign ev_mem_capture = c.mbr_mem;
  assign ev_ir_load     = c.ir_all | c.ir_addr;
  assign cyc_bits       = cyc_q;
  assign step_bits      = step;

  hwseq_timer u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (!halted_q),
    .last (c.last),
    .step (step)
  );

  hwseq_decode #(.W(OPC_W)) u_dec (
    .opc(op_field),
    .oh (op_oh)
  );

  hwseq_ctrl u_ctrl (
    .cyc     (cyc_q),
    .step    (step),
    .op_oh   (op_oh),
    .mbr     (mbr),
    .irq_pend(irq_req & ien_q),
    .halted  (halted_q),
    .c       (c)
  );

  hwseq_regs #(.SAVE_ADDR(SAVE_ADDR), .ISR_ADDR(ISR_ADDR)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .c        (c),
    .mem_rdata(mem_rdata),
    .mar      (mar),
    .mbr      (mbr),
    .pc       (pc),
    .op_field (op_field),
    .acc      (acc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q    <= CYC_FETCH;
      ien_q    <= 1'b1;
      halted_q <= 1'b0;
    end else begin
      if (c.last)     cyc_q    <= c.next;
      if (c.ien_clr)  ien_q    <= 1'b0;
      if (c.halt_set) halted_q <= 1'b1;
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_rd    = c.mem_rd;
  assign mem_wr    = c.mem_wr;
  assign halted    = halted_q;
  assign acc_out   = acc;
  assign pc_out    = pc;

endmodule

// File: rtl/hwseq_checks.sv
module hwseq_checks #(
  parameter logic [11:0] SAVE_ADDR = 12'h000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [11:0] mem_addr,
  input logic        halted,
  input logic        ev_mar_load,
  input logic        ev_mem_capture,
  input logic        ev_ir_load,
  input logic [1:0]  cyc_bits,
  input logic [1:0]  step_bits
);

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  assert_capture_vs_ir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_mem_capture && ev_ir_load));

  assert_mar_before_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> $past(ev_mar_load));

  assert_step_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_bits != $past(cyc_bits)) |-> (step_bits == 2'd0));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_rd && !mem_wr));

  assert_save_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_bits == 2'd3 && step_bits == 2'd2 && !halted) |-> (mem_wr && mem_addr == SAVE_ADDR));

endmodule

bind hwseq_core hwseq_checks #(.SAVE_ADDR(SAVE_ADDR)) u_checks (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_rd        (mem_rd),
  .mem_wr        (mem_wr),
  .mem_addr      (mem_addr),
  .halted        (halted),
  .ev_mar_load   (ev_mar_load),
  .ev_mem_capture(ev_mem_capture),
  .ev_ir_load    (ev_ir_load),
  .cyc_bits      (cyc_bits),
  .step_bits     (step_bits)
);

// File: tb/tb_hwseq_core.sv
`timescale 1ns/1ps
module tb_hwseq_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_req = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] acc_out;
  logic [11:0] pc_out;

  always #4 clk = ~clk;

  hwseq_core dut (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .halted(halted),
    .acc_out(acc_out), .pc_out(pc_out)
  );

  // memory model: read within the strobe cycle, write on the edge
  logic [15:0] mem [0:255];
  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  typedef struct { logic [11:0] a; logic [15:0] d; string tag; } wr_t;
  wr_t   exp_q[$];
  int    n_chk = 0, n_fail = 0;
  string cur_tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push_wr(input logic [11:0] a, input logic [15:0] d, input string tag);
    wr_t e;
    e.a = a; e.d = d; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // encode an instruction word: bit15 indirect, 14:12 opcode, 11:0 address
  function automatic logic [15:0] ins(input bit ind, input int op, input int x);
    return {ind, 3'(op), 12'(x)};
  endfunction

  function automatic logic [15:0] sum16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0];
  endfunction

  // scoreboard monitor: every write compared in order
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (exp_q.size() == 0) begin
        check(1'b0, cur_tag, "unexpected write", {4'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check(mem_addr == e.a && mem_wdata == e.d, e.tag, "memory write",
              {4'h0, mem_addr, mem_wdata}, {4'h0, e.a, e.d});
      end
    end
  end

  task automatic start_prog(input string tag, input bit irq);
    rst_n = 1'b0;
    cur_tag = tag;
    irq_req = irq;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = 16'h7000;
  endtask

  task automatic run_prog(input bit probe, output int n);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
      if (probe && n == 1) begin
        check(mem_rd == 1'b1 && mem_wr == 1'b0, "R2", "t2 read strobe", {30'h0, mem_rd, mem_wr}, 32'h2);
        check(mem_addr == 12'h000, "R2", "t2 address is old PC", 32'(mem_addr), 32'h0);
        check(pc_out == 12'h000, "R2", "PC before t2 edge", 32'(pc_out), 32'h0);
      end
      if (probe && n == 2) begin
        check(pc_out == 12'h001 && mem_rd == 1'b0, "R2", "t3 PC advanced, no read",
              {19'h0, mem_rd, pc_out}, 32'h001);
      end
    end
    check(halted == 1'b1, cur_tag, "program halted", 32'(halted), 32'h1);
    check(exp_q.size() == 0, cur_tag, "pending expected writes", 32'(exp_q.size()), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, cur_tag, "watchdog expired", 32'h0, 32'h1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(pc_out == 12'h000, "R1", "PC in reset", 32'(pc_out), 32'h0);
    check(acc_out == 16'h0000, "R1", "ACC in reset", 32'(acc_out), 32'h0);
    check(!halted && !mem_rd && !mem_wr, "R1", "halt/strobes in reset",
          {29'h0, halted, mem_rd, mem_wr}, 32'h0);

    // Program A: two direct ADDs with wrap, then HLT (R3, R4, R8)
    start_prog("R4", 1'b0);
    mem[0] = ins(0, 0, 12'h020);
    mem[1] = ins(0, 0, 12'h021);
    mem[2] = ins(0, 7, 0);
    mem[12'h20] = 16'h1234;
    mem[12'h21] = 16'hF000;
    run_prog(1'b1, n);
    check(acc_out == sum16(16'h1234, 16'hF000), "R4", "ACC sum mod 2^16", 32'(acc_out), 32'(sum16(16'h1234, 16'hF000)));
    check(n == 6 + 6 + 4, "R8", "halt clock count", n, 16);
    check(pc_out == 12'h003, "R3/R8", "PC after HLT", 32'(pc_out), 32'h3);
    repeat (4) @(negedge clk);
    check(halted && !mem_rd && !mem_wr && pc_out == 12'h003, "R8", "halt holds",
          {17'h0, halted, mem_rd, mem_wr, pc_out}, {17'h0, 3'b100, 12'h003});

    // Program B: ISZ with and without skip (R5)
    start_prog("R5", 1'b0);
    mem[0] = ins(0, 1, 12'h030);
    mem[1] = ins(0, 0, 12'h031);
    mem[2] = ins(0, 1, 12'h032);
    mem[3] = ins(0, 0, 12'h033);
    mem[4] = ins(0, 7, 0);
    mem[12'h30] = 16'hFFFF;
    mem[12'h31] = 16'h0100;
    mem[12'h32] = 16'h0005;
    mem[12'h33] = 16'h0007;
    push_wr(12'h030, 16'h0000, "R5");
    push_wr(12'h032, 16'h0006, "R5");
    run_prog(1'b0, n);
    check(acc_out == 16'h0007, "R5", "skipped ADD not executed", 32'(acc_out), 32'h7);
    check(pc_out == 12'h005, "R5", "PC after skip program", 32'(pc_out), 32'h5);
    check(n == 7 + 7 + 6 + 4, "R5", "ISZ clock count", n, 24);
    check(mem[12'h30] == 16'h0000 && mem[12'h32] == 16'h0006, "R5", "ISZ memory",
          {mem[12'h30], mem[12'h32]}, 32'h00000006);

    // Program C: BSA (R6)
    start_prog("R6", 1'b0);
    mem[0] = ins(0, 2, 12'h040);
    mem[12'h41] = ins(0, 0, 12'h050);
    mem[12'h42] = ins(0, 7, 0);
    mem[12'h50] = 16'h0009;
    push_wr(12'h040, 16'h0001, "R6");
    run_prog(1'b0, n);
    check(acc_out == 16'h0009, "R6", "resumed at X+1", 32'(acc_out), 32'h9);
    check(pc_out == 12'h043, "R6", "PC after BSA program", 32'(pc_out), 32'h43);
    check(n == 6 + 6 + 4, "R6", "BSA clock count", n, 16);

    // Program D: indirect forms of ADD, ISZ, BSA (R7)
    start_prog("R7", 1'b0);
    mem[0] = ins(1, 0, 12'h060);
    mem[1] = ins(1, 1, 12'h061);
    mem[2] = ins(1, 2, 12'h062);
    mem[12'h60] = 16'hA070;
    mem[12'h61] = 16'hF072;
    mem[12'h62] = 16'h0080;
    mem[12'h70] = 16'h0011;
    mem[12'h72] = 16'h0003;
    mem[12'h81] = ins(0, 7, 0);
    push_wr(12'h072, 16'h0004, "R7");
    push_wr(12'h080, 16'h0003, "R7");
    run_prog(1'b0, n);
    check(acc_out == 16'h0011, "R7", "indirect ADD", 32'(acc_out), 32'h11);
    check(pc_out == 12'h082, "R7", "indirect BSA target", 32'(pc_out), 32'h82);
    check(n == 9 + 10 + 9 + 4, "R7", "indirect clock count", n, 32);
    check(mem[12'h60] == 16'hA070, "R7", "pointer untouched", 32'(mem[12'h60]), 32'hA070);

    // Program E: no-op opcodes and one interrupt with request held (R9, R10)
    start_prog("R9", 1'b1);
    mem[0] = ins(0, 3, 12'h021);
    mem[1] = ins(0, 6, 12'h025);
    mem[2] = ins(0, 0, 12'h021);
    mem[3] = ins(0, 7, 0);
    mem[12'h21] = 16'h0005;
    mem[12'h25] = 16'h0044;
    push_wr(12'h000, 16'h0001, "R9");
    run_prog(1'b0, n);
    check(acc_out == 16'h0005, "R10", "no-op left ACC", 32'(acc_out), 32'h5);
    check(pc_out == 12'h004, "R9", "PC after service run", 32'(pc_out), 32'h4);
    check(mem[0] == 16'h0001, "R9", "return address saved", 32'(mem[0]), 32'h1);
    check(mem[12'h25] == 16'h0044, "R10", "no-op left memory", 32'(mem[12'h25]), 32'h44);
    check(n == 4 + 3 + 4 + 6 + 4, "R9", "interrupt clock count", n, 21);

    irq_req = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule